// File: doc/BRIEF.md
# Pin Interrupt and Wake Trigger Detector

This block sits behind a bank of input pins that have already been filtered. For each pin it decides when a trigger condition has happened, keeps an interrupt status bit and a wake status bit, and drives an interrupt request for that pin. Software sets up each pin with a trigger-style bit (edge or level), a two-bit polarity code, an interrupt enable, a separate interrupt mask, and one wake enable for each low-power state. The current system power state chooses which of the wake enables applies. Software clears the status bits with one-cycle clear strobes, one per pin.

Edge detection compares the pin against the value it had in the previous cycle. Level detection looks at the pin value as it is now. The enable bit decides whether a trigger is recorded in the interrupt status at all. The mask bit only holds back the request output. The wake status records the same trigger when the wake enable for the present power state is set. In a level-style pin the status keeps setting again for as long as the active level stays. The block also reports every pin's registered level on its own output, whatever the interrupt configuration is.

Top module: `pin_trig_top`

## Requirements
- R1: While reset is asserted, every bit of `intSts`, `wakeSts`, `intPending` and `pinLevel` is 0.
- R2: `pinLevel[i]` equals the `pinIn[i]` value that was sampled at the previous clock edge, whatever the configuration is.
- R3: When `trigLevel[i]`=0 (edge style), polarity code 01 triggers on a rising edge, 00 on a falling edge and 10 on either edge. `intSts[i]` goes to 1 on the clock edge where the new pin value is first sampled, and it stays 1 until it is cleared.
- R4: Polarity code 11 never triggers, in either style. Code 10 never triggers in level style.
- R5: When `trigLevel[i]`=1 (level style), code 01 triggers while the pin is high and 00 triggers while it is low. A clear strobe has no effect while the active level is present. It clears the status once the level has gone.
- R6: While `intEn[i]`=0, a trigger does not set `intSts[i]`.
- R7: `intPending[i]` is 1 exactly when `intSts[i]`, `intEn[i]` and `intMask[i]` are all 1. A mask value of 0 holds back the request and keeps the status. Raising the mask makes the request appear in the same cycle.
- R8: `powerState` uses 0 for running, 1 for light sleep, 2 for suspend and 3 for soft-off. `wakeEn[i*3+s-1]` enables wake in state s. `wakeSts[i]` goes to 1 on a trigger when the enable for the current state is 1. It never sets in state 0. It is cleared by `clrWake[i]`.
- R9: `clrInt[i]` clears `intSts[i]` on the next clock edge. If a trigger that is recorded arrives in the same cycle as the clear, the trigger wins. The same holds for `clrWake[i]` against a wake trigger.
- R10: The first clock edge after reset is released detects no edge. A pin that is already high at release does not produce a rising-edge event.
- R11: A clear strobe on one pin leaves the status of every other pin unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pinIn | input | NUM_PINS | Filtered pin values |
| trigLevel | input | NUM_PINS | 1 = level style, 0 = edge style |
| actLevel | input | 2*NUM_PINS | Polarity code for each pin, in bits [2i+1:2i] |
| intEn | input | NUM_PINS | Interrupt enable |
| intMask | input | NUM_PINS | Interrupt mask, 1 = unmasked |
| wakeEn | input | 3*NUM_PINS | Wake enable for each pin and sleep state |
| powerState | input | 2 | Current system power state |
| clrInt | input | NUM_PINS | Interrupt status clear strobes |
| clrWake | input | NUM_PINS | Wake status clear strobes |
| intSts | output | NUM_PINS | Interrupt status |
| wakeSts | output | NUM_PINS | Wake status |
| intPending | output | NUM_PINS | Interrupt request |
| pinLevel | output | NUM_PINS | Registered pin level |

## Verification
The bench builds the block with three pins and three wake states. Three pins are enough to give each pin a different polarity code in the same cycle and to check that clears stay within their own pin. Three wake states cover every power-state code, including the running state, which never wakes. A random phase also switches the trigger style, the polarity codes and the power state while clears are arriving, so that trigger-against-clear collisions happen in every mode.

// File: rtl/pintrig_pkg.sv
package pintrig_pkg;

  // Polarity codes (field value on actLevel)
  localparam logic [1:0] POL_LOW  = 2'b00;
  localparam logic [1:0] POL_HIGH = 2'b01;
  localparam logic [1:0] POL_BOTH = 2'b10;

  // Per-pin strobes from the detector to the status datapath
  typedef struct packed {
    logic intHit;   // trigger condition this cycle
    logic wakeHit;  // trigger qualified by wake enable of current state
  } trig_strobe_t;

endpackage

// File: rtl/pin_trig_ctrl.sv
module pin_trig_ctrl
  import pintrig_pkg::*;
#(
  parameter int NUM_PINS    = 4,
  parameter int WAKE_STATES = 3,
  localparam int PS_W       = $clog2(WAKE_STATES + 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_PINS-1:0]             pinIn,
  input  logic [NUM_PINS-1:0]             trigLevel,
  input  logic [2*NUM_PINS-1:0]           actLevel,
  input  logic [WAKE_STATES*NUM_PINS-1:0] wakeEn,
  input  logic [PS_W-1:0]                 powerState,
  output logic [NUM_PINS-1:0]             pinLevel,
  output trig_strobe_t [NUM_PINS-1:0]     strobes
);

  logic [NUM_PINS-1:0] prevIn;
  logic                armed;

  // Edge history is valid only once one sample has been taken after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevIn <= '0;
      armed  <= 1'b0;
    end else begin
      prevIn <= pinIn;
      armed  <= 1'b1;
    end
  end

  assign pinLevel = prevIn;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [1:0] pol;
    logic       rise;
    logic       fall;
    logic       edgeHit;
    logic       lvlHit;
    logic       wakeSel;

    assign pol  = actLevel[2*i +: 2];
    assign rise = armed &  pinIn[i] & ~prevIn[i];
    assign fall = armed & ~pinIn[i] &  prevIn[i];

    always_comb begin
      unique case (pol)
        POL_HIGH: edgeHit = rise;
        POL_LOW:  edgeHit = fall;
        POL_BOTH: edgeHit = rise | fall;
        default:  edgeHit = 1'b0;
      endcase
    end

    always_comb begin
      unique case (pol)
        POL_HIGH: lvlHit = pinIn[i];
        POL_LOW:  lvlHit = ~pinIn[i];
        default:  lvlHit = 1'b0;
      endcase
    end

    // Pick the wake enable belonging to the current power state; state 0 runs
    always_comb begin
      wakeSel = 1'b0;
      for (int s = 1; s <= WAKE_STATES; s++) begin
        if (powerState == PS_W'(s)) wakeSel = wakeEn[i*WAKE_STATES + s - 1];
      end
    end

    assign strobes[i].intHit  = trigLevel[i] ? lvlHit : edgeHit;
    assign strobes[i].wakeHit = strobes[i].intHit & wakeSel;

    // R4: the undefined polarity code never produces a trigger
    p_code11_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pol == 2'b11) |-> !strobes[i].intHit);

    // R8: running state never qualifies a wake
    p_run_no_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (powerState == '0) |-> !strobes[i].wakeHit);
  end

endmodule

// File: rtl/pin_trig_status.sv
module pin_trig_status
  import pintrig_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  trig_strobe_t [NUM_PINS-1:0] strobes,
  input  logic [NUM_PINS-1:0]         intEn,
  input  logic [NUM_PINS-1:0]         intMask,
  input  logic [NUM_PINS-1:0]         clrInt,
  input  logic [NUM_PINS-1:0]         clrWake,
  output logic [NUM_PINS-1:0]         intSts,
  output logic [NUM_PINS-1:0]         wakeSts,
  output logic [NUM_PINS-1:0]         intPending
);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic intSet;

    assign intSet = strobes[i].intHit & intEn[i];

    // Set has priority over clear
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          intSts[i] <= 1'b0;
      else if (intSet)     intSts[i] <= 1'b1;
      else if (clrInt[i])  intSts[i] <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  wakeSts[i] <= 1'b0;
      else if (strobes[i].wakeHit) wakeSts[i] <= 1'b1;
      else if (clrWake[i])         wakeSts[i] <= 1'b0;
    end

    assign intPending[i] = intSts[i] & intEn[i] & intMask[i];

    // R6: status only rises when the enable was set
    p_set_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(intSts[i]) |-> $past(intEn[i]));

    // R3: status holds without a clear
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (intSts[i] && !clrInt[i]) |=> intSts[i]);

    // R9: a clear with no recorded trigger empties the status
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clrInt[i] && !(strobes[i].intHit && intEn[i])) |=> !intSts[i]);

    // R9: recorded trigger wins over a simultaneous clear
    p_trig_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (strobes[i].intHit && intEn[i] && clrInt[i]) |=> intSts[i]);

    // R8: wake clear without a wake trigger empties the wake status
    p_wake_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clrWake[i] && !strobes[i].wakeHit) |=> !wakeSts[i]);
  end

endmodule

// File: rtl/pin_trig_top.sv
module pin_trig_top
  import pintrig_pkg::*;
#(
  parameter int NUM_PINS    = 4,
  parameter int WAKE_STATES = 3,
  localparam int PS_W       = $clog2(WAKE_STATES + 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_PINS-1:0]             pinIn,
  input  logic [NUM_PINS-1:0]             trigLevel,
  input  logic [2*NUM_PINS-1:0]           actLevel,
  input  logic [NUM_PINS-1:0]             intEn,
  input  logic [NUM_PINS-1:0]             intMask,
  input  logic [WAKE_STATES*NUM_PINS-1:0] wakeEn,
  input  logic [PS_W-1:0]                 powerState,
  input  logic [NUM_PINS-1:0]             clrInt,
  input  logic [NUM_PINS-1:0]             clrWake,
  output logic [NUM_PINS-1:0]             intSts,
  output logic [NUM_PINS-1:0]             wakeSts,
  output logic [NUM_PINS-1:0]             intPending,
  output logic [NUM_PINS-1:0]             pinLevel
);

  trig_strobe_t [NUM_PINS-1:0] strobes;

  pin_trig_ctrl #(.NUM_PINS(NUM_PINS), .WAKE_STATES(WAKE_STATES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .pinIn      (pinIn),
    .trigLevel  (trigLevel),
    .actLevel   (actLevel),
    .wakeEn     (wakeEn),
    .powerState (powerState),
    .pinLevel   (pinLevel),
    .strobes    (strobes)
  );

  pin_trig_status #(.NUM_PINS(NUM_PINS)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .intEn      (intEn),
    .intMask    (intMask),
    .clrInt     (clrInt),
    .clrWake    (clrWake),
    .intSts     (intSts),
    .wakeSts    (wakeSts),
    .intPending (intPending)
  );

  // R1: outputs stay low while reset is asserted
  always_comb begin
    if (!rst_n) begin
      a_reset_quiet_r1: assert (intSts == '0 && wakeSts == '0 && pinLevel == '0);
    end
  end

endmodule

// File: tb/tb_pin_trig_top.sv
module tb_pin_trig_top;
  localparam int N  = 3;
  localparam int WS = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    pinIn = '0, trigLevel = '0, intEn = '0, intMask = '0;
  logic [N-1:0]    clrInt = '0, clrWake = '0;
  logic [2*N-1:0]  actLevel = '0;
  logic [WS*N-1:0] wakeEn = '0;
  logic [1:0]      powerState = '0;
  logic [N-1:0]    intSts, wakeSts, intPending, pinLevel;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  pin_trig_top #(.NUM_PINS(N), .WAKE_STATES(WS)) dut (
    .clk(clk), .rst_n(rst_n), .pinIn(pinIn), .trigLevel(trigLevel),
    .actLevel(actLevel), .intEn(intEn), .intMask(intMask), .wakeEn(wakeEn),
    .powerState(powerState), .clrInt(clrInt), .clrWake(clrWake),
    .intSts(intSts), .wakeSts(wakeSts), .intPending(intPending),
    .pinLevel(pinLevel)
  );

  // Behavioural reference model
  bit mSts[N], mWake[N], mPrev[N];
  bit mArmed = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mArmed = 0;
      for (int i = 0; i < N; i++) begin mSts[i] = 0; mWake[i] = 0; mPrev[i] = 0; end
    end else begin
      for (int i = 0; i < N; i++) begin
        bit up, dn, hit, wsel;
        int code;
        code = actLevel[2*i +: 2];
        up = mArmed && pinIn[i] && !mPrev[i];
        dn = mArmed && !pinIn[i] && mPrev[i];
        if (trigLevel[i])
          hit = (code == 1 && pinIn[i]) || (code == 0 && !pinIn[i]);
        else
          hit = (code == 1 && up) || (code == 0 && dn) || (code == 2 && (up || dn));
        wsel = (powerState != 0) && wakeEn[i*WS + powerState - 1];
        if (hit && intEn[i]) mSts[i] = 1; else if (clrInt[i]) mSts[i] = 0;
        if (hit && wsel) mWake[i] = 1; else if (clrWake[i]) mWake[i] = 0;
        mPrev[i] = pinIn[i];
      end
      mArmed = 1;
    end
  end

  // Compare every cycle away from the clock edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int i = 0; i < N; i++) begin
        bit pend;
        pend = mSts[i] && intEn[i] && intMask[i];
        checks++;
        if (intSts[i] !== mSts[i]) begin failures++;
          $display("FAIL R3 model intSts[%0d] act=%0b exp=%0b t=%0t", i, intSts[i], mSts[i], $time); end
        if (wakeSts[i] !== mWake[i]) begin failures++;
          $display("FAIL R8 model wakeSts[%0d] act=%0b exp=%0b t=%0t", i, wakeSts[i], mWake[i], $time); end
        if (intPending[i] !== pend) begin failures++;
          $display("FAIL R7 model intPending[%0d] act=%0b exp=%0b t=%0t", i, intPending[i], pend, $time); end
        if (pinLevel[i] !== mPrev[i]) begin failures++;
          $display("FAIL R2 model pinLevel[%0d] act=%0b exp=%0b t=%0t", i, pinLevel[i], mPrev[i], $time); end
      end
    end
  end

  task automatic tick();
    @(posedge clk); #5;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic clearAll();
    clrInt = '1; clrWake = '1; tick(); clrInt = '0; clrWake = '0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    pinIn = 3'b001; actLevel = 6'b000001; intEn = 3'b001; intMask = 3'b001;
    repeat (3) tick();
    chk("R1 intSts", intSts, 0);
    chk("R1 wakeSts", wakeSts, 0);
    chk("R1 intPending", intPending, 0);
    chk("R1 pinLevel", pinLevel, 0);
    rst_n = 1'b1;
    tick(); tick();
    chk("R10 no edge after reset", intSts, 0);
    chk("R2 pinLevel", pinLevel, 3'b001);

    // R3 rising edge and hold
    pinIn = 0; tick(); pinIn = 3'b001; tick();
    chk("R3 rising sets", intSts[0], 1);
    chk("R7 pending", intPending[0], 1);
    tick(); tick();
    chk("R3 holds", intSts[0], 1);
    clrInt = 3'b001; tick(); clrInt = 0;
    chk("R9 clear", intSts[0], 0);

    // R7 mask
    intMask = 0; pinIn = 0; tick(); pinIn = 3'b001; tick();
    chk("R7 masked status kept", intSts[0], 1);
    chk("R7 masked no pending", intPending[0], 0);
    intMask = 3'b001; #1;
    chk("R7 unmask pending", intPending[0], 1);
    clearAll();

    // R9 trigger beats clear (falling)
    actLevel = 6'b000000; pinIn = 0; clrInt = 3'b001; tick(); clrInt = 0;
    chk("R9 trigger wins", intSts[0], 1);
    clearAll();

    // R4 code 11 and level code 10
    actLevel = 6'b000011; pinIn = 3'b001; tick(); pinIn = 0; tick();
    chk("R4 code11 edge", intSts[0], 0);
    trigLevel = 3'b001; tick(); pinIn = 3'b001; tick();
    chk("R4 code11 level", intSts[0], 0);
    actLevel = 6'b000010; tick(); pinIn = 0; tick();
    chk("R4 code10 level", intSts[0], 0);

    // R5 level active high
    actLevel = 6'b000001; pinIn = 3'b001; tick();
    chk("R5 level sets", intSts[0], 1);
    clrInt = 3'b001; tick(); clrInt = 0;
    chk("R5 clear blocked", intSts[0], 1);
    pinIn = 0; clrInt = 3'b001; tick(); clrInt = 0;
    chk("R5 clear after level", intSts[0], 0);
    actLevel = 6'b000000; tick();
    chk("R5 level low sets", intSts[0], 1);
    pinIn = 3'b001; clrInt = 3'b001; tick(); clrInt = 0;
    chk("R5 low cleared", intSts[0], 0);
    trigLevel = 0;

    // R6 enable off
    intEn = 0; actLevel = 6'b000010; pinIn = 0; tick(); pinIn = 3'b001; tick();
    chk("R6 disabled", intSts[0], 0);
    intEn = 3'b001;

    // R8 wake per state
    powerState = 2; wakeEn = 9'b000000010; pinIn = 0; tick();
    chk("R8 wake in suspend", wakeSts[0], 1);
    chk("R3 both-edge falling", intSts[0], 1);
    clearAll();
    chk("R8 wake cleared", wakeSts[0], 0);
    powerState = 0; pinIn = 3'b001; tick();
    chk("R8 no wake running", wakeSts[0], 0);
    powerState = 3; pinIn = 0; tick();
    chk("R8 disabled state", wakeSts[0], 0);
    clearAll(); powerState = 0; wakeEn = 0;

    // R11 independent clears
    actLevel = 6'b010110; intEn = '1; intMask = '1; pinIn = 3'b110; tick();
    chk("R11 two pins set", intSts, 3'b110);
    clrInt = 3'b010; tick(); clrInt = 0;
    chk("R11 other pin kept", intSts, 3'b100);
    clearAll();

    // Random phase, compared against the model every cycle
    for (int c = 0; c < 4000; c++) begin
      pinIn = N'($urandom);
      if (c % 50 == 0) begin
        trigLevel = N'($urandom); actLevel = (2*N)'($urandom);
        intEn = N'($urandom); intMask = N'($urandom);
        wakeEn = (WS*N)'($urandom); powerState = 2'($urandom);
      end
      clrInt  = N'($urandom) & N'($urandom);
      clrWake = N'($urandom) & N'($urandom);
      tick();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule